// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block keeps the programmable division ratio for an SPI master's serial clock and produces that clock from the module clock. Software reaches the ratio through a small register port: one 32-bit word at a fixed offset in the block's address window. The ratio lives in the low 16 bits. The block also takes the master-enable level from a separate control register. Writes are accepted only while that enable is low. Because of this, the ratio cannot change while a transfer is running.

Only even ratios can be stored, and a ratio of zero turns the clock off. While the master is enabled and the ratio is non-zero, the serial clock runs at the module clock rate divided by the ratio, with equal high and low times. Alongside the clock, the block gives one-cycle rise and fall strobes in the module clock domain. A shift engine can use these to launch and capture data without ever clocking on the divided signal.

Top module: `spi_sclk_divider`

## Requirements
- R1: The ratio register answers at byte offset 0x14 with the ratio in bits 15:0 and zeros in bits 31:16. Any other offset reads as all zeros.
- R2: Bit 0 of the stored ratio is always 0. A write stores bits 15:1 of the write data and discards bit 0.
- R3: After reset the stored ratio reads 0, the serial clock is low and neither strobe is asserted.
- R4: With a stored ratio of 0, the serial clock stays low and no strobe fires, even while the master is enabled.
- R5: A write while the master enable is high leaves the stored ratio unchanged. The running clock keeps its period.
- R6: While enabled with an even ratio D from 2 to 65534, the serial clock toggles every D/2 module clock cycles, so its period is D cycles and its duty cycle is 50%.
- R7: After the enable rises, the serial clock first goes high exactly D/2 module clock cycles later (counted in rising edges of the module clock with the enable high).
- R8: One cycle after the enable goes low, the serial clock is low and no strobe is asserted. The next enable starts again from the idle state.
- R9: The rise strobe is high for exactly the cycle in which the serial clock first reads high after being low. The fall strobe is high for exactly the cycle in which it first reads low after a toggle. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master enable level from the control register |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| sclk | output | 1 | Serial clock, idles low |
| sclk_rise | output | 1 | One-cycle strobe at each serial clock rising edge |
| sclk_fall | output | 1 | One-cycle strobe at each serial clock falling edge |

## Verification
Random ratios, including odd and out-of-range write values, show whether bit 0 is forced low and bits above 15 are dropped on read-back. Random offsets show whether the register decodes only at its own address. Each even ratio is run for several periods and compared cycle by cycle against a computed waveform, which exposes errors in the first-edge latency, half-period length and strobe placement. The directed cases are ratio 2 (toggle every cycle), ratio 0 while enabled, a write issued mid-transfer, and disabling with the clock high. These tell off-by-one reload values apart from faults in write protection and idle-state recovery.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

   // Register geometry shared by the divider blocks.
   localparam int unsigned BUS_W       = 32;
   localparam int unsigned RATIO_W     = 16;
   localparam int unsigned OFFS_W      = 8;
   localparam int unsigned RATIO_OFFS  = 'h14;

   // Edge strobes handed to the shift engine.
   typedef struct packed {
      logic rise;
      logic fall;
   } sclk_strobe_t;

endpackage

// File: rtl/sclk_div_reg.sv
module sclk_div_reg #(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned REG_W  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned OFFSET = 'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [DIV_W-1:0]  div_o
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

   generate
      if (DIV_W < 2) begin : g_bad_width
         $error("sclk_div_reg: DIV_W must be at least 2");
      end
      if (DIV_W > REG_W) begin : g_bad_fit
         $error("sclk_div_reg: DIV_W must fit in REG_W");
      end
      if (OFFSET >= (64'd1 << ADDR_W)) begin : g_bad_offs
         $error("sclk_div_reg: OFFSET outside the address window");
      end
   endgenerate

   logic             hit;
   logic             wr_ok;
   logic [DIV_W-1:0] div_q;

   assign hit   = (addr == HIT_ADDR);
   assign wr_ok = wr && hit && !master_en;

   // Low bit is never stored: only even ratios exist.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (wr_ok) begin
         div_q <= {wdata[DIV_W-1:1], 1'b0};
      end
   end

   assign rdata = hit ? REG_W'(div_q) : '0;
   assign div_o = div_q;

endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen
   import sclk_div_pkg::*;
#(
   parameter int unsigned DIV_W        = 16,
   parameter bit          STROBE_AHEAD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_i,
   output logic             sclk_o,
   output sclk_strobe_t     strobe_o
);

   localparam int unsigned HALF_W = DIV_W - 1;

   logic [HALF_W-1:0] half;
   logic [HALF_W-1:0] cnt_q;
   logic              sclk_q;
   logic              run;
   logic              tick;

   assign half = div_i[DIV_W-1:1];
   assign run  = en && (half != '0);
   assign tick = run && (cnt_q == (half - HALF_W'(1)));

   // Half-period counter; idle state whenever not running.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!run) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (tick) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + HALF_W'(1);
      end
   end

   generate
      if (STROBE_AHEAD) begin : g_ahead
         // Strobes one cycle before the level changes.
         assign strobe_o.rise = tick && !sclk_q;
         assign strobe_o.fall = tick &&  sclk_q;
      end else begin : g_aligned
         // Strobes coincide with the new level.
         logic rise_q;
         logic fall_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rise_q <= 1'b0;
               fall_q <= 1'b0;
            end else begin
               rise_q <= tick && !sclk_q;
               fall_q <= tick &&  sclk_q;
            end
         end
         assign strobe_o.rise = rise_q;
         assign strobe_o.fall = fall_q;
      end
   endgenerate

   assign sclk_o = sclk_q;

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
   import sclk_div_pkg::*;
#(
   parameter int unsigned DIV_W        = RATIO_W,
   parameter int unsigned REG_W        = BUS_W,
   parameter int unsigned ADDR_W       = OFFS_W,
   parameter int unsigned OFFSET       = RATIO_OFFS,
   parameter bit          STROBE_AHEAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              sclk,
   output logic              sclk_rise,
   output logic              sclk_fall
);

   logic [DIV_W-1:0] div_val;
   sclk_strobe_t     strobe;

   sclk_div_reg #(
      .DIV_W  (DIV_W),
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W),
      .OFFSET (OFFSET)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_en (master_en),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .div_o     (div_val)
   );

   // The ratio only changes while disabled, so the generator sees a
   // value that is frozen for the whole of every enabled interval.
   sclk_div_gen #(
      .DIV_W        (DIV_W),
      .STROBE_AHEAD (STROBE_AHEAD)
   ) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (master_en),
      .div_i    (div_val),
      .sclk_o   (sclk),
      .strobe_o (strobe)
   );

   assign sclk_rise = strobe.rise;
   assign sclk_fall = strobe.fall;

endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk #(
   parameter int unsigned DIV_W        = 16,
   parameter bit          STROBE_AHEAD = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             master_en,
   input logic [DIV_W-1:0] div_val,
   input logic             sclk,
   input logic             rise,
   input logic             fall
);

   assert_even_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
      div_val[0] == 1'b0);

   assert_write_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      master_en |=> $stable(div_val));

   assert_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (div_val == '0) |-> !sclk);

   assert_disable_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> !sclk);

   assert_no_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));

   generate
      if (!STROBE_AHEAD) begin : g_aligned_chk
         assert_rise_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rise == $rose(sclk));
         assert_fall_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fall |-> $fell(sclk));
         assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !master_en |=> (!rise && !fall));
      end
   endgenerate

endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(
   .DIV_W        (DIV_W),
   .STROBE_AHEAD (STROBE_AHEAD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .master_en (master_en),
   .div_val   (div_val),
   .sclk      (sclk),
   .rise      (sclk_rise),
   .fall      (sclk_fall)
);

// File: tb/spi_sclk_divider_test.sv
module spi_sclk_divider_test;

   localparam logic [7:0] OFFS = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        master_en;
   logic [7:0]  reg_addr;
   logic        reg_wr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        sclk;
   logic        sclk_rise;
   logic        sclk_fall;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   spi_sclk_divider uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_en (master_en),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sclk      (sclk),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_stored(input logic [31:0] w);
      return {16'h0, w[15:1], 1'b0};
   endfunction

   function automatic logic exp_sclk(input int k, input int d);
      int h = d / 2;
      if (h == 0) return 1'b0;
      return ((k / h) % 2) == 1;
   endfunction

   function automatic logic exp_rise(input int k, input int d);
      int h = d / 2;
      if (h == 0) return 1'b0;
      return (k % h == 0) && ((k / h) % 2 == 1);
   endfunction

   function automatic logic exp_fall(input int k, input int d);
      int h = d / 2;
      if (h == 0 || k == 0) return 1'b0;
      return (k % h == 0) && ((k / h) % 2 == 0);
   endfunction

   task automatic reg_write(input logic [7:0] a, input logic [31:0] w);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = w;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   // Enable with ratio d already stored; check n cycles, then disable.
   task automatic run_window(input int d, input int n, input int poke_at,
                             input logic [31:0] poke_val);
      master_en = 1'b1;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (d == 0) begin
            chk("R4 sclk", sclk, 1'b0);
            chk("R4 strobes", {sclk_rise, sclk_fall}, 2'b00);
         end else if (k <= d / 2) begin
            chk("R7 first edge sclk", sclk, exp_sclk(k, d));
            chk("R9 rise", sclk_rise, exp_rise(k, d));
         end else begin
            chk("R6 sclk", sclk, exp_sclk(k, d));
            chk("R9 rise", sclk_rise, exp_rise(k, d));
            chk("R9 fall", sclk_fall, exp_fall(k, d));
         end
         if (k == poke_at) begin
            reg_addr  = OFFS;
            reg_wdata = poke_val;
            reg_wr    = 1'b1;
         end else begin
            reg_wr    = 1'b0;
         end
      end
      reg_wr    = 1'b0;
      master_en = 1'b0;
      @(negedge clk);
      chk("R8 sclk low", sclk, 1'b0);
      chk("R8 strobes quiet", {sclk_rise, sclk_fall}, 2'b00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] w;
      logic [7:0]  a;
      int          seed_init;
      seed_init = $urandom(32'h5EED_0042);

      rst_n     = 1'b0;
      master_en = 1'b0;
      reg_addr  = OFFS;
      reg_wr    = 1'b0;
      reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: reset state
      reg_read(OFFS, v);
      chk("R3 ratio after reset", v, 32'h0);
      chk("R3 sclk after reset", {sclk, sclk_rise, sclk_fall}, 3'b000);

      // R2: odd write values
      reg_write(OFFS, 32'd7);
      reg_read(OFFS, v);
      chk("R2 odd 7", v, 32'd6);
      reg_write(OFFS, 32'd1);
      reg_read(OFFS, v);
      chk("R2 odd 1", v, 32'd0);
      // R1: upper bits dropped, 0xFFFF holds 0xFFFE
      reg_write(OFFS, 32'hABCD_FFFF);
      reg_read(OFFS, v);
      chk("R1 upper zero", v, 32'h0000_FFFE);
      reg_read(8'h10, v);
      chk("R1 other offset", v, 32'h0);

      // R4: zero ratio while enabled
      reg_write(OFFS, 32'd0);
      run_window(0, 40, 0, 32'h0);

      // R6/R7: ratio 2, toggle every cycle
      reg_write(OFFS, 32'd2);
      run_window(2, 12, 0, 32'h0);

      // R5: write during a transfer is ignored
      reg_write(OFFS, 32'd6);
      run_window(6, 30, 8, 32'd20);
      reg_read(OFFS, v);
      chk("R5 blocked write", v, 32'd6);
      master_en = 1'b1;
      reg_write(OFFS, 32'd10);
      master_en = 1'b0;
      reg_read(OFFS, v);
      chk("R5 blocked write 2", v, 32'd6);

      // R8: disable while high, then restart from idle
      reg_write(OFFS, 32'd8);
      run_window(8, 5, 0, 32'h0);
      run_window(8, 20, 0, 32'h0);

      // Random mix
      for (int i = 0; i < 16; i++) begin
         w = $urandom;
         w = {w[31:16], 16'(w[5:0] % 41)};
         reg_write(OFFS, w);
         reg_read(OFFS, v);
         chk("R2 random store", v, exp_stored(w));
         if (v[15:0] != 16'h0)
            run_window(int'(v[15:0]), 2 * int'(v[15:0]) + 3, 0, 32'h0);
         a = 8'($urandom);
         if (a != OFFS) begin
            reg_read(a, v);
            chk("R1 random offset", v, 32'h0);
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule